// File: doc/BRIEF.md
# Timer-Linked Capture/Compare Unit

This block combines a 16-bit up-counter with a 16-bit holding register that either records the counter or is compared against it. A 4-bit mode field picks the behaviour. In the capture modes, edges on a pin latch the counter into the holding register. The pin passes through a two-flop synchroniser before edges are detected on the system clock, and the pin is sampled on every clock. In the compare modes, equality between the counter and the holding register does one of four things: it raises an output pin, lowers it, only raises the interrupt flag, or triggers a special event. The special event clears the counter, so the holding register sets the period, and it emits a converter start pulse.

The counter advances by one on each clock where `tmr_inc` is high. Where that enable comes from is decided outside this block. Software uses a byte-wide register port. Address 0 holds the mode in bits 3:0. Address 1 is the low byte of the holding register and address 2 is its high byte. At address 3, bit 0 is the interrupt flag; writing it sets the flag to that bit. Reads are combinational on `reg_addr`. All other pins are plain level or single-cycle strobe signals, with no handshake.

Top module: `tmr_capcmp`

## Requirements
- R1: After reset, the counter, the holding register, the mode, the interrupt flag, the compare pin and all strobes are zero.
- R2: Each clock with `tmr_inc` high adds one to the counter. Going from 0xFFFF to 0 raises `tmr_ovf` for exactly one cycle, unless the special event clears the counter in that cycle.
- R3: Mode 0x4 captures on each falling edge of the synchronised pin and mode 0x5 on each rising edge. A capture copies the counter value into the holding register and sets the flag. The opposite edge does nothing.
- R4: Mode 0x6 captures on every 4th rising edge and mode 0x7 on every 16th. A 4-bit edge counter, cleared only by reset, advances on each rising edge in these two modes. A capture happens when its two low bits are 11 (mode 0x6) or when all four bits are 1 (mode 0x7).
- R5: Mode writes never clear the edge counter, so the first capture after switching from 0x7 to 0x6 can come after fewer than four edges.
- R6: A write that changes the mode from one capture mode (0x4 to 0x7) to a different capture mode sets the flag. Other mode writes leave the flag alone.
- R7: A match drives the compare pin high in mode 0x8 and low in mode 0x9, and sets the flag in both modes.
- R8: In mode 0xA a match sets the flag and leaves the compare pin unchanged.
- R9: In mode 0xB a match clears the counter instead of incrementing it. It also pulses `tmr_rst_strobe` for one cycle, pulses `conv_start` for one cycle when `conv_en` is high, and never raises `tmr_ovf`, even at 0xFFFF.
- R10: In mode 0x0 the compare pin goes low on the next clock, and no edge or counter value sets the flag or loads the holding register.
- R11: A match is only evaluated on a clock with `tmr_inc` high. Equal values with the increment idle have no effect.
- R12: When a capture and a software write to the holding register or to the flag fall in the same clock, the capture wins.
- R13: The capture is registered on the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 low byte, 2 high byte, 3 flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cap_pin | input | 1 | Asynchronous capture pin |
| tmr_inc | input | 1 | Counter increment enable |
| conv_en | input | 1 | Converter enabled; gates `conv_start` |
| cmp_pin | output | 1 | Compare output pin |
| irq_flag | output | 1 | Interrupt flag |
| tmr_value | output | 16 | Current counter value |
| tmr_ovf | output | 1 | One-cycle overflow pulse |
| tmr_rst_strobe | output | 1 | One-cycle special-event counter reset pulse |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
A capture and a software write to the same holding register, or to the flag, can land on the same clock edge. The bench provokes this by placing the write exactly on the third clock after a pin change, where the capture is registered. It then judges that the holding register shows the counter value, not the written byte, and that the flag stays set despite a write of zero. A second collision, a special-event clear at counter value 0xFFFF, is run to confirm that the counter returns to zero without an overflow pulse.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int MODE_W = 4;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t M_OFF       = 4'h0;
  localparam mode_t M_CAP_FALL  = 4'h4;
  localparam mode_t M_CAP_RISE  = 4'h5;
  localparam mode_t M_CAP_DIV4  = 4'h6;
  localparam mode_t M_CAP_DIV16 = 4'h7;
  localparam mode_t M_CMP_SET   = 4'h8;
  localparam mode_t M_CMP_CLR   = 4'h9;
  localparam mode_t M_CMP_IRQ   = 4'hA;
  localparam mode_t M_CMP_TRIG  = 4'hB;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_LO   = 2'd1;
  localparam logic [1:0] A_HI   = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  function automatic logic is_cap(mode_t m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/capcmp_edge_sync.sv
module capcmp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchroniser flops followed by one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

  // R13: an edge is seen only after the pin value has travelled the chain
  p_rise_delayed_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_q[STAGES-1]) |-> $past(sh_q[STAGES-2]));
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture import capcmp_pkg::*; #(
  parameter int DIV_SMALL = 4,
  parameter int DIV_BIG   = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  mode_wr_i,
  input  mode_t mode_new_i,
  output logic  cap_o,
  output logic  switch_o
);
  localparam int PRE_W   = $clog2(DIV_BIG);
  localparam int SMALL_W = $clog2(DIV_SMALL);

  logic [PRE_W-1:0] cnt_q;
  logic counting, small_hit, big_hit;

  assign counting  = rise_i && (mode_i == M_CAP_DIV4 || mode_i == M_CAP_DIV16);
  assign small_hit = &cnt_q[SMALL_W-1:0];
  assign big_hit   = &cnt_q;

  // edge counter: cleared by reset only, never by a mode write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (counting) cnt_q <= cnt_q + 1'b1;
  end

  assign cap_o = (mode_i == M_CAP_FALL  && fall_i) ||
                 (mode_i == M_CAP_RISE  && rise_i) ||
                 (mode_i == M_CAP_DIV4  && rise_i && small_hit) ||
                 (mode_i == M_CAP_DIV16 && rise_i && big_hit);

  assign switch_o = mode_wr_i && is_cap(mode_i) && is_cap(mode_new_i) &&
                    (mode_new_i != mode_i);

  // R5: the counter moves only on rising edges in the divided modes
  p_pre_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> ($past(rise_i) && $past(mode_i[3:1]) == 3'b011));
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare import capcmp_pkg::*; #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_t         mode_i,
  input  logic [TW-1:0] tmr_i,
  input  logic [TW-1:0] ccpr_i,
  input  logic          inc_i,
  input  logic          conv_en_i,
  output logic          match_o,
  output logic          special_o,
  output logic          pin_o,
  output logic          trig_o,
  output logic          conv_o
);
  logic cmp_mode;

  assign cmp_mode  = (mode_i == M_CMP_SET) || (mode_i == M_CMP_CLR) ||
                     (mode_i == M_CMP_IRQ) || (mode_i == M_CMP_TRIG);
  assign match_o   = inc_i && cmp_mode && (tmr_i == ccpr_i);
  assign special_o = match_o && (mode_i == M_CMP_TRIG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_o  <= 1'b0;
      trig_o <= 1'b0;
      conv_o <= 1'b0;
    end else begin
      if (mode_i == M_OFF)                     pin_o <= 1'b0;
      else if (match_o && mode_i == M_CMP_SET) pin_o <= 1'b1;
      else if (match_o && mode_i == M_CMP_CLR) pin_o <= 1'b0;
      trig_o <= special_o;
      conv_o <= special_o && conv_en_i;
    end
  end

  // R11: the pin only moves after an increment clock, or when forced off
  p_pin_needs_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_o) |-> ($past(inc_i) || $past(mode_i) == M_OFF));
  // R10: mode off drives the pin low on the next clock
  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_OFF) |=> !pin_o);
endmodule

// File: rtl/tmr_capcmp.sv
module tmr_capcmp import capcmp_pkg::*; #(
  parameter int TW            = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int CAP_DIV_SMALL = 4,
  parameter int CAP_DIV_BIG   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [TW/2-1:0] reg_wdata,
  output logic [TW/2-1:0] reg_rdata,
  input  logic            cap_pin,
  input  logic            tmr_inc,
  input  logic            conv_en,
  output logic            cmp_pin,
  output logic            irq_flag,
  output logic [TW-1:0]   tmr_value,
  output logic            tmr_ovf,
  output logic            tmr_rst_strobe,
  output logic            conv_start
);
  localparam int DW = TW / 2;

  mode_t          mode_q;
  logic [TW-1:0]  tmr_q, ccpr_q;
  logic           flag_q, ovf_q;
  logic           rise, fall, cap_evt, sw_evt, match, special, mode_wr;

  assign mode_wr = reg_wr && (reg_addr == A_MODE);

  capcmp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .rise_o(rise), .fall_o(fall));

  capcmp_capture #(.DIV_SMALL(CAP_DIV_SMALL), .DIV_BIG(CAP_DIV_BIG)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .rise_i(rise), .fall_i(fall),
    .mode_wr_i(mode_wr), .mode_new_i(reg_wdata[MODE_W-1:0]),
    .cap_o(cap_evt), .switch_o(sw_evt));

  capcmp_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .tmr_i(tmr_q), .ccpr_i(ccpr_q),
    .inc_i(tmr_inc), .conv_en_i(conv_en), .match_o(match), .special_o(special),
    .pin_o(cmp_pin), .trig_o(tmr_rst_strobe), .conv_o(conv_start));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= tmr_inc && !special && (&tmr_q);
      if (special)      tmr_q <= '0;
      else if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      ccpr_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= reg_wdata[MODE_W-1:0];
      if (cap_evt)                             ccpr_q          <= tmr_q;
      else if (reg_wr && reg_addr == A_LO)     ccpr_q[DW-1:0]  <= reg_wdata;
      else if (reg_wr && reg_addr == A_HI)     ccpr_q[TW-1:DW] <= reg_wdata;
      if (cap_evt || match || sw_evt)          flag_q <= 1'b1;
      else if (reg_wr && reg_addr == A_FLAG)   flag_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {{(DW-MODE_W){1'b0}}, mode_q};
      A_LO:    reg_rdata = ccpr_q[DW-1:0];
      A_HI:    reg_rdata = ccpr_q[TW-1:DW];
      default: reg_rdata = {{(DW-1){1'b0}}, flag_q};
    endcase
  end

  assign tmr_value = tmr_q;
  assign tmr_ovf   = ovf_q;
  assign irq_flag  = flag_q;

  p_tmr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_inc && !special) |=> (tmr_q == $past(tmr_q) + 1'b1));
  p_ovf_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |-> (tmr_q == '0));
  p_trig_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    special |=> (tmr_q == '0 && tmr_rst_strobe && !tmr_ovf));
  p_cap_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (ccpr_q == $past(tmr_q) && irq_flag));
  p_sw_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |=> irq_flag);
endmodule

// File: tb/tmr_capcmp_tb_top.sv
module tmr_capcmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        cap_pin = 1'b0;
  logic        tmr_inc = 1'b0;
  logic        conv_en = 1'b0;
  logic        cmp_pin, irq_flag, tmr_ovf, tmr_rst_strobe, conv_start;
  logic [15:0] tmr_value;

  always #5 clk = ~clk;

  tmr_capcmp dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
    .tmr_inc(tmr_inc), .conv_en(conv_en), .cmp_pin(cmp_pin),
    .irq_flag(irq_flag), .tmr_value(tmr_value), .tmr_ovf(tmr_ovf),
    .tmr_rst_strobe(tmr_rst_strobe), .conv_start(conv_start));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected state from the requirements
  logic [15:0] e_tmr = 16'd0, e_ccpr = 16'd0;
  logic [3:0]  e_mode = 4'd0;
  bit e_flag, e_pin, e_ovf, e_trig, e_conv;
  int e_cnt = 0;
  bit pend = 1'b0, pend_rise = 1'b0, pin_drv = 1'b0, conv_en_tb = 1'b0;
  int age = 0;

  function automatic bit capm(logic [3:0] m); return m >= 4'h4 && m <= 4'h7; endfunction
  function automatic bit cmpm(logic [3:0] m); return m >= 4'h8 && m <= 4'hB; endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // one clock: drive at a falling edge, model the rising edge, check at next falling edge
  task automatic cycle(bit inc, bit wr, logic [1:0] a, logic [7:0] d, string req);
    bit match, sp, capt, rs, fl, sw;
    tmr_inc = inc; reg_wr = wr; reg_addr = a; reg_wdata = d; conv_en = conv_en_tb;
    if (cap_pin != pin_drv) begin
      cap_pin = pin_drv; pend = 1'b1; age = 0; pend_rise = pin_drv;
    end
    match = inc && cmpm(e_mode) && (e_tmr == e_ccpr);
    sp    = match && (e_mode == 4'hB);
    capt  = 1'b0;
    if (pend) begin
      if (age == 2) begin                      // R13: third edge after the change
        pend = 1'b0; rs = pend_rise; fl = !pend_rise;
        capt = (e_mode == 4'h4 && fl) || (e_mode == 4'h5 && rs) ||
               (e_mode == 4'h6 && rs && (e_cnt % 4 == 3)) ||
               (e_mode == 4'h7 && rs && e_cnt == 15);
        if (rs && (e_mode == 4'h6 || e_mode == 4'h7)) e_cnt = (e_cnt + 1) % 16;
      end else age++;
    end
    sw = wr && a == 2'd0 && capm(e_mode) && capm(d[3:0]) && d[3:0] != e_mode;
    if (e_mode == 4'h0) e_pin = 1'b0;
    else if (match && e_mode == 4'h8) e_pin = 1'b1;
    else if (match && e_mode == 4'h9) e_pin = 1'b0;
    if (capt) e_ccpr = e_tmr;
    else if (wr && a == 2'd1) e_ccpr[7:0] = d;
    else if (wr && a == 2'd2) e_ccpr[15:8] = d;
    if (capt || match || sw) e_flag = 1'b1;
    else if (wr && a == 2'd3) e_flag = d[0];
    if (wr && a == 2'd0) e_mode = d[3:0];
    e_ovf  = inc && !sp && e_tmr == 16'hFFFF;
    e_trig = sp;
    e_conv = sp && conv_en_tb;
    if (sp) e_tmr = 16'd0; else if (inc) e_tmr = e_tmr + 16'd1;
    @(negedge clk);
    reg_wr = 1'b0; tmr_inc = 1'b0;
    chk(req, "tmr_value", tmr_value, e_tmr);
    chk(req, "tmr_ovf", tmr_ovf, e_ovf);
    chk(req, "tmr_rst_strobe", tmr_rst_strobe, e_trig);
    chk(req, "conv_start", conv_start, e_conv);
    chk(req, "cmp_pin", cmp_pin, e_pin);
    chk(req, "irq_flag", irq_flag, e_flag);
    reg_addr = 2'd1; #1 chk(req, "hold_lo", reg_rdata, e_ccpr[7:0]);
    reg_addr = 2'd2; #1 chk(req, "hold_hi", reg_rdata, e_ccpr[15:8]);
    reg_addr = 2'd0; #1 chk(req, "mode", reg_rdata, {4'd0, e_mode});
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 2'd0, 8'd0, req);
  endtask
  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 2'd0, 8'd0, req);
  endtask
  task automatic wreg(logic [1:0] a, logic [7:0] d, string req);
    cycle(1'b0, 1'b1, a, d, req);
  endtask
  task automatic set_hold(logic [15:0] v, string req);
    wreg(2'd1, v[7:0], req); wreg(2'd2, v[15:8], req);
  endtask
  task automatic pulse(string req);
    pin_drv = 1'b1; idle(4, req);
    wreg(2'd3, 8'd0, req);
    pin_drv = 1'b0; idle(4, req);
    wreg(2'd3, 8'd0, req);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1, "R1");

    // R2: sparse and dense increments, then a full wrap with overflow pulse
    for (int i = 0; i < 20; i++) cycle(i[0], 1'b0, 2'd0, 8'd0, "R2");
    run(65536 - int'(e_tmr) + 2, "R2");

    // R10: mode off, edges are ignored
    pulse("R10");
    pulse("R10");

    // R6: entering a capture mode from off leaves the flag
    wreg(2'd0, 8'h04, "R6");
    // R3: falling-edge captures at several counter values
    for (int k = 0; k < 4; k++) begin
      run(3 + 7 * k, "R3");
      pulse("R3");
    end
    wreg(2'd0, 8'h05, "R6");           // capture to capture switch sets flag
    wreg(2'd3, 8'd0, "R6");
    for (int k = 0; k < 4; k++) begin
      run(5 + 11 * k, "R3");
      pulse("R3");
    end
    run(9, "R13");
    pulse("R13");

    // R4: divided captures
    wreg(2'd0, 8'h06, "R6");
    wreg(2'd3, 8'd0, "R6");
    wreg(2'd0, 8'h06, "R6");           // same value: no flag
    for (int k = 0; k < 8; k++) begin
      run(2 + k, "R4");
      pulse("R4");
    end
    wreg(2'd0, 8'h07, "R6");
    wreg(2'd3, 8'd0, "R6");
    for (int k = 0; k < 13; k++) begin
      run(1 + k, "R4");
      pulse("R4");
    end
    // R5: counter left mid-way, switch to the divide-by-4 mode, early capture
    wreg(2'd0, 8'h06, "R5");
    wreg(2'd3, 8'd0, "R5");
    for (int k = 0; k < 4; k++) begin
      run(4, "R5");
      pulse("R5");
    end

    // R12: capture coincides with a holding-register write, then with a flag write
    wreg(2'd0, 8'h05, "R12");
    wreg(2'd3, 8'd0, "R12");
    run(6, "R12");
    pin_drv = 1'b1;
    idle(2, "R12");
    wreg(2'd1, 8'h5A, "R12");
    idle(2, "R12");
    wreg(2'd0, 8'h04, "R12");
    run(3, "R12");
    pin_drv = 1'b0;
    idle(2, "R12");
    wreg(2'd3, 8'd0, "R12");
    idle(2, "R12");
    wreg(2'd3, 8'd0, "R12");
    idle(2, "R12");

    // R11 and R7: compare with increment idle, then on increments
    wreg(2'd0, 8'h08, "R7");
    set_hold(e_tmr, "R11");
    idle(4, "R11");
    run(1, "R7");
    wreg(2'd3, 8'd0, "R7");
    wreg(2'd0, 8'h09, "R7");
    set_hold(e_tmr + 16'd2, "R7");
    run(4, "R7");
    wreg(2'd0, 8'h08, "R7");
    wreg(2'd3, 8'd0, "R7");
    set_hold(e_tmr + 16'd1, "R7");
    run(3, "R7");
    wreg(2'd3, 8'd0, "R8");
    wreg(2'd0, 8'h0A, "R8");
    set_hold(e_tmr + 16'd2, "R8");
    run(4, "R8");
    wreg(2'd0, 8'h00, "R10");
    idle(2, "R10");
    wreg(2'd3, 8'd0, "R10");
    run(5, "R10");

    // R9: special event with and without converter enable, then at 0xFFFF
    conv_en_tb = 1'b1;
    set_hold(e_tmr + 16'd3, "R9");
    wreg(2'd0, 8'h0B, "R9");
    run(12, "R9");
    conv_en_tb = 1'b0;
    run(9, "R9");
    wreg(2'd0, 8'h00, "R9");
    set_hold(16'hFFFF, "R9");
    wreg(2'd0, 8'h0B, "R9");
    conv_en_tb = 1'b1;
    run(65536 - int'(e_tmr) + 3, "R9");
    wreg(2'd0, 8'h00, "R10");
    idle(2, "R10");

    done = 1'b1;
    report();
    $finish;
  end
endmodule